// File: doc/BRIEF.md
# Monochrome Bitmap Raster Video Generator

The block produces the full raster for a one-bit-per-pixel display and feeds it from a frame buffer that is 16 bits wide. It runs one pixel per clock. The pixel clock is twice the processor clock. Three counters track the raster: a pixel index inside a 16-pixel word slot, a slot index inside the line, and a line index inside the frame. During each picture slot the block issues a single word read. The read returns after a fixed latency, and the block shifts the word out one pixel per clock, least significant bit first. Alongside the pixels it drives an active-picture flag, a blanking flag and a composite sync.

With the default parameters a line has 44 slots (704 clocks) and a frame has 370 lines. Lines 0 to 341 carry 32 picture words each. Horizontal sync sits in slots 36 and 37. Lines 353 to 355 carry vertical sync with the horizontal pattern inverted. The fetch side runs one slot ahead of the display side. The word for a slot is therefore read while the previous slot is on screen, and the shifter reloads with no gap. All outputs describe the display position, which lags the fetch counters by 16 clocks.

Two frame bases are built in: a main base (word 0xD380) and an alternate base (word 0x9380). A select input is sampled on the frame-start strobe. It picks the base that the address counter reloads to at the end of that frame, so the choice applies to the following frame.

Top module: `mono_raster_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, and for the first 16 clocks after it is released, `active_o`=0, `blank_o`=1, `csync_o`=0, `pix_o`=0 and `frame_o`=0. The first frame after reset reads from the main base.
- R2: One line lasts SLOTS*16 clocks and one frame lasts LINES lines. `frame_o` is high for exactly one clock, at display pixel 0 of slot 0 of line 0, and first rises 16 clocks after reset release.
- R3: `active_o` is high exactly on display lines below PIC_LINES and slots below PIC_SLOTS.
- R4: On lines outside the vertical sync band, `csync_o` is high only in slots HS_START to HS_END-1. `blank_o` is high whenever neither `active_o` nor `csync_o` is high.
- R5: On lines VS_START to VS_END-1, `csync_o` is the inverse of the horizontal pattern: low in slots HS_START to HS_END-1 and high in every other slot.
- R6: `mem_req_o` is high for one clock at the first clock of every picture slot of the fetch position, which leads the display by one slot. `mem_addr_o` starts each frame at its base and rises by one per request.
- R7: Read data is taken from `mem_data_i` exactly RD_LAT clocks after the request clock. It is ignored at all other times.
- R8: Pixel p (0..15) of a slot shows bit p of that slot's word, so bit 0 is shown first and bit 15 last.
- R9: `pix_o` is 0 whenever `active_o` is 0.
- R10: `buf_sel_i` is sampled only on the clock where `frame_o` is high. Value 0 selects the main base and value 1 selects the alternate base, and the choice applies to the next frame. Changes at any other time have no effect.
- R11: A reset applied mid-frame restores the R1 state. Counting restarts at line 0, slot 0, and the main base is used regardless of the previous selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| buf_sel_i | input | 1 | Frame buffer select (0 main, 1 alternate) |
| mem_req_o | output | 1 | Word read request, one clock per picture slot |
| mem_addr_o | output | ADDR_W | Word address of the request |
| mem_data_i | input | 16 | Read data, valid RD_LAT clocks after the request |
| pix_o | output | 1 | Serial pixel |
| active_o | output | 1 | Picture area |
| blank_o | output | 1 | Blanking level (neither picture nor sync) |
| csync_o | output | 1 | Composite sync |
| frame_o | output | 1 | Frame-start strobe |

## Verification
A full default frame takes over 260,000 clocks, so the bench builds the block with a reduced geometry. It uses 10 slots per line with 4 picture slots and sync in slots 6 and 7, and 12 lines per frame with 4 picture lines and vertical sync on lines 7 and 8. The read latency is 2, and the bases are 0x0100 and 0x0800. These values keep every region of the line and frame, and the inverted sync lines, while letting seven frames run. That is enough to reach several buffer-select changes, a select glitch between strobes and a reset in the middle of a frame. The memory model returns a marker word whenever no read is due, so a capture at the wrong latency corrupts the pixels.

// File: rtl/mono_raster_gen.sv
module mono_raster_gen #(
  parameter int SLOTS     = 44,
  parameter int PIC_SLOTS = 32,
  parameter int HS_START  = 36,
  parameter int HS_END    = 38,
  parameter int LINES     = 370,
  parameter int PIC_LINES = 342,
  parameter int VS_START  = 353,
  parameter int VS_END    = 356,
  parameter int RD_LAT    = 1,
  parameter int ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] MAIN_BASE = 16'hD380,
  parameter logic [ADDR_W-1:0] ALT_BASE  = 16'h9380
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              buf_sel_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [15:0]       mem_data_i,
  output logic              pix_o,
  output logic              active_o,
  output logic              blank_o,
  output logic              csync_o,
  output logic              frame_o
);
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int LINE_W = $clog2(LINES);

  logic [3:0]        pix;
  logic [SLOT_W-1:0] slot, dslot;
  logic [LINE_W-1:0] line, dline;
  logic              dvalid, sel_q;
  logic [ADDR_W-1:0] addr;
  logic [15:0]       pre, sh;
  logic [RD_LAT-1:0] vpipe;

  wire last_pix  = pix == 4'd15;
  wire last_slot = slot == SLOT_W'(SLOTS - 1);
  wire last_line = line == LINE_W'(LINES - 1);
  wire fetch_pic = (slot < SLOT_W'(PIC_SLOTS)) && (line < LINE_W'(PIC_LINES));

  assign mem_req_o  = fetch_pic && pix == 4'd0;
  assign mem_addr_o = addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pix  <= '0;
      slot <= '0;
      line <= '0;
    end else begin
      pix <= pix + 4'd1;
      if (last_pix) begin
        slot <= last_slot ? '0 : slot + 1'b1;
        if (last_slot) line <= last_line ? '0 : line + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) addr <= MAIN_BASE;
    else if (last_pix && last_slot && last_line) addr <= sel_q ? ALT_BASE : MAIN_BASE;
    else if (mem_req_o) addr <= addr + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vpipe <= '0;
      pre   <= '0;
    end else begin
      vpipe <= RD_LAT'({vpipe, mem_req_o});
      if (vpipe[RD_LAT-1]) pre <= mem_data_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dvalid <= 1'b0;
      dslot  <= '0;
      dline  <= '0;
      sh     <= '0;
    end else if (last_pix) begin
      dvalid <= 1'b1;
      dslot  <= slot;
      dline  <= line;
      sh     <= fetch_pic ? pre : 16'h0000;
    end else begin
      sh <= sh >> 1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sel_q <= 1'b0;
    else if (frame_o) sel_q <= buf_sel_i;
  end

  wire hs_zone = (dslot >= SLOT_W'(HS_START)) && (dslot < SLOT_W'(HS_END));
  wire vs_zone = (dline >= LINE_W'(VS_START)) && (dline < LINE_W'(VS_END));

  assign active_o = dvalid && (dslot < SLOT_W'(PIC_SLOTS)) && (dline < LINE_W'(PIC_LINES));
  assign csync_o  = dvalid && (vs_zone ? !hs_zone : hs_zone);
  assign blank_o  = !active_o && !csync_o;
  assign pix_o    = sh[0];
  assign frame_o  = dvalid && dslot == '0 && dline == '0 && pix == 4'd0;

  assert_single_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |=> !mem_req_o);
  assert_addr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && slot != '0) |-> mem_addr_o == $past(mem_addr_o, 16) + 1'b1);
  assert_sync_outside_picture_R4: assert property (@(posedge clk) disable iff (!rst_n)
    active_o |-> !csync_o);
  assert_dark_outside_picture_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !active_o |-> !pix_o);
  assert_frame_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_o |=> !frame_o);
endmodule

// File: tb/tb_mono_raster_gen.sv
`timescale 1ns/1ps
module tb_mono_raster_gen;
  localparam int SL = 10, PS = 4, HSS = 6, HSE = 8;
  localparam int LN = 12, PL = 4, VSS = 7, VSE = 9, LAT = 2;
  localparam logic [15:0] MB = 16'h0100, AB = 16'h0800;
  localparam int LINE_CLK = SL * 16, FRAME = LINE_CLK * LN;

  logic clk = 1'b0, rst_n = 1'b0, buf_sel = 1'b0;
  logic mem_req, pix, active, blank, csync, frame;
  logic [15:0] mem_addr, mem_data;
  logic [15:0] a1, a2;
  logic v1, v2;

  always #10 clk = ~clk;

  mono_raster_gen #(.SLOTS(SL), .PIC_SLOTS(PS), .HS_START(HSS), .HS_END(HSE),
    .LINES(LN), .PIC_LINES(PL), .VS_START(VSS), .VS_END(VSE), .RD_LAT(LAT),
    .ADDR_W(16), .MAIN_BASE(MB), .ALT_BASE(AB)) dut (
    .clk(clk), .rst_n(rst_n), .buf_sel_i(buf_sel), .mem_req_o(mem_req),
    .mem_addr_o(mem_addr), .mem_data_i(mem_data), .pix_o(pix), .active_o(active),
    .blank_o(blank), .csync_o(csync), .frame_o(frame));

  function automatic logic [15:0] fdat(logic [15:0] a);
    return (a * 16'h003B) ^ 16'hA5C3 ^ {a[7:0], a[15:8]};
  endfunction

  always @(posedge clk) begin
    a1 <= mem_addr; v1 <= mem_req;
    a2 <= a1;       v2 <= v1;
  end
  assign mem_data = v2 ? fdat(a2) : 16'hDEAD;

  int k = 0, nchk = 0, nfail = 0;
  bit sel_hist [0:63];
  string rtag = "R1";

  function automatic int base_of(int fr);
    if (fr == 0) return int'(MB);
    return sel_hist[(fr - 1) % 64] ? int'(AB) : int'(MB);
  endfunction

  task automatic chk(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h (k=%0d)", tag, act, exp, k);
    end
  endtask

  task automatic check_all();
    int d, pos, fr, ln, sl, px, fk, ff, fl, fs;
    bit act, hs, vs, sy, req;
    logic [15:0] w;
    d = rst_n ? k - 16 : -1;
    if (d < 0) begin
      chk(rtag, active, 0); chk(rtag, blank, 1); chk(rtag, csync, 0);
      chk(rtag, pix, 0);    chk(rtag, frame, 0);
    end else begin
      pos = d % FRAME; fr = d / FRAME;
      ln = pos / LINE_CLK; sl = (pos % LINE_CLK) / 16; px = pos % 16;
      act = ln < PL && sl < PS;
      hs = sl >= HSS && sl < HSE;
      vs = ln >= VSS && ln < VSE;
      sy = vs ? !hs : hs;
      chk("R3", active, act);
      chk(vs ? "R5" : "R4", csync, sy);
      chk("R4", blank, !act && !sy);
      chk("R2", frame, pos == 0);
      if (pos == 0) sel_hist[fr % 64] = buf_sel;
      if (act) begin
        w = fdat(16'(base_of(fr) + ln * PS + sl));
        chk(fr > 0 ? "R10" : "R7_R8", pix, w[px]);
      end else chk("R9", pix, 0);
    end
    if (rst_n) begin
      fk = k % FRAME; ff = k / FRAME;
      fl = fk / LINE_CLK; fs = (fk % LINE_CLK) / 16;
      req = (fk % 16 == 0) && fl < PL && fs < PS;
      chk("R6", mem_req, req);
      if (req) chk(ff > 0 ? "R10" : (rtag == "R11" ? "R11" : "R6"),
                   mem_addr, base_of(ff) + fl * PS + fs);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    if (!rst_n) k = 0; else k++;
    @(negedge clk);
    check_all();
  endtask

  task automatic run_to(int target);
    while (k < target) cyc();
  endtask

  task automatic t_reset();
    rtag = "R1"; rst_n = 1'b0; buf_sel = 1'b0;
    repeat (4) cyc();
    rst_n = 1'b1;
    repeat (20) cyc();
  endtask

  task automatic t_main_frames();
    run_to(2 * FRAME);
  endtask

  task automatic t_buffer_select();
    run_to(2 * FRAME + 500);  buf_sel = 1'b1;
    run_to(2 * FRAME + 1000); buf_sel = 1'b0;
    run_to(3 * FRAME + 500);  buf_sel = 1'b1;
    run_to(6 * FRAME + 700);
  endtask

  task automatic t_mid_reset();
    rtag = "R11"; rst_n = 1'b0;
    repeat (3) cyc();
    rst_n = 1'b1;
    run_to(FRAME + 100);
  endtask

  initial begin
    #(200000 * 20);
    nfail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_main_frames();
    t_buffer_select();
    t_mid_reset();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule